// File: doc/BRIEF.md
# Bit-Serial Unsigned Adder with Registered Sum Bit

This block adds two unsigned operands one bit pair per clock. A start request copies both operands into their own shift registers. Each add cycle consumes the two least significant bits and advances a four-state carry machine, and the resulting sum bits move into a result register. The machine keeps the freshly produced sum bit in its state, so each result bit leaves the machine one clock after the pair that made it. A final flush cycle therefore moves the last sum bit and the outgoing carry into place.

A caller drives both operands with the start request held high for one cycle while the block is idle. It then waits for the completion pulse and reads the full-width result, which stays unchanged until the next accepted start. Requests that arrive during an addition are dropped.

Top module: `serial_moore_adder`

## Requirements
- R1: A synchronous active-high reset leaves `sum_out` at 0 and both `busy` and `done` low.
- R2: A `go` sampled high while `busy` is low is accepted at that clock edge. In the next cycle `busy` is 1 and `sum_out` reads 0.
- R3: When `done` is high, `sum_out` equals `a_in + b_in` as captured at the accepted edge. Bit 8 holds the carry out of bit 7.
- R4: `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R5: A `go` or an operand change while `busy` is high has no effect on the addition under way or on its result.
- R6: While idle and with `go` low, `sum_out` holds its value, whatever the operand inputs do.
- R7: Because each sum bit is registered in the carry machine, an addition takes 8 add cycles plus 1 flush cycle. `busy` stays high for exactly 9 cycles after the accepting edge, and `done` follows in the next cycle.
- R8: The carry machine restarts in its zero-carry, zero-sum state for every addition, so a carry left over from an earlier addition never reaches a later one.
- R9: If `go` is held high through the completion cycle, a new addition is accepted at the clock edge that ends the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Start request, taken only while idle |
| a_in | input | 8 | First unsigned operand |
| b_in | input | 8 | Second unsigned operand |
| sum_out | output | 9 | Result, valid from the `done` cycle until the next start |
| busy | output | 1 | An addition is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a carry leaking from one addition into the next. Reaching it needs a run that ends in the carry-set state, followed straight away by a run whose correct result depends on starting with a clear carry. The bench ends one addition at 255+255 and keeps `go` high through the `done` cycle, so the next addition, 0+0, starts in the very next cycle. It also changes `go` and the operands throughout a run to show that inputs are ignored while busy.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

    // State code: bit 1 is the stored carry, bit 0 is the sum bit made on entry.
    typedef enum logic [1:0] {
        ST_G0 = 2'b00,
        ST_G1 = 2'b01,
        ST_H0 = 2'b10,
        ST_H1 = 2'b11
    } add_state_e;

    function automatic logic state_carry(input add_state_e st);
        return st[1];
    endfunction

    function automatic logic state_sum(input add_state_e st);
        return st[0];
    endfunction

    // One step of the carry machine for a single bit pair.
    function automatic add_state_e next_state(input logic abit, input logic bbit,
                                              input add_state_e cur);
        logic c;
        logic s;
        logic nc;
        c  = state_carry(cur);
        s  = abit ^ bbit ^ c;
        nc = (abit & bbit) | (abit & c) | (bbit & c);
        return add_state_e'({nc, s});
    endfunction

endpackage

// File: rtl/serial_add_oprnd_sr.sv
module serial_add_oprnd_sr #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] din,
    output logic             lsb
);
    logic [WIDTH-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (load) begin
            bits_q <= din;
        end else if (shift) begin
            bits_q <= {1'b0, bits_q[WIDTH-1:1]};
        end
    end

    assign lsb = bits_q[0];
endmodule

// File: rtl/serial_add_moore_fsm.sv
module serial_add_moore_fsm
    import serial_add_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       step_en,
    input  logic       abit,
    input  logic       bbit,
    output add_state_e state,
    output logic       sbit,
    output logic       carry
);
    add_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state_q <= ST_G0;
        end else if (step_en) begin
            state_q <= next_state(abit, bbit, state_q);
        end
    end

    assign state = state_q;
    assign sbit  = state_sum(state_q);
    assign carry = state_carry(state_q);
endmodule

// File: rtl/serial_add_ctrl.sv
module serial_add_ctrl #(
    parameter int OP_W  = 8,
    parameter int CNT_W = $clog2(OP_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    output logic             start,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OP_W);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;

    assign start = go && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (busy_q) begin
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign cnt  = cnt_q;
endmodule

// File: rtl/serial_add_result.sv
module serial_add_result #(
    parameter int OP_W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          shift_en,
    input  logic          take_carry,
    input  logic          sbit,
    input  logic          carry,
    output logic [OP_W:0] res
);
    logic [OP_W:0] res_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            res_q <= '0;
        end else begin
            if (shift_en) begin
                res_q[OP_W-1:0] <= {sbit, res_q[OP_W-1:1]};
            end
            if (take_carry) begin
                res_q[OP_W] <= carry;
            end
        end
    end

    assign res = res_q;
endmodule

// File: rtl/serial_moore_adder.sv
module serial_moore_adder
    import serial_add_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [OP_W-1:0] a_in,
    input  logic [OP_W-1:0] b_in,
    output logic [OP_W:0] sum_out,
    output logic          busy,
    output logic          done
);
    localparam int CNT_W = $clog2(OP_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OP_W);

    logic             start;
    logic [CNT_W-1:0] step_cnt;
    logic             adding;
    logic             a_bit;
    logic             b_bit;
    logic             s_bit;
    logic             c_bit;
    add_state_e       fsm_state;

    serial_add_ctrl #(.OP_W(OP_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .go(go), .start(start),
        .busy(busy), .done(done), .cnt(step_cnt)
    );

    assign adding = busy && (step_cnt != LAST);

    serial_add_oprnd_sr #(.WIDTH(OP_W)) u_sr_a (
        .clk(clk), .rst(rst), .load(start), .shift(adding),
        .din(a_in), .lsb(a_bit)
    );

    serial_add_oprnd_sr #(.WIDTH(OP_W)) u_sr_b (
        .clk(clk), .rst(rst), .load(start), .shift(adding),
        .din(b_in), .lsb(b_bit)
    );

    serial_add_moore_fsm u_fsm (
        .clk(clk), .rst(rst), .clear(start), .step_en(adding),
        .abit(a_bit), .bbit(b_bit), .state(fsm_state),
        .sbit(s_bit), .carry(c_bit)
    );

    serial_add_result #(.OP_W(OP_W)) u_res (
        .clk(clk), .rst(rst), .clear(start),
        .shift_en(busy && (step_cnt != '0)),
        .take_carry(busy && (step_cnt == LAST)),
        .sbit(s_bit), .carry(c_bit), .res(sum_out)
    );
endmodule

// File: rtl/serial_moore_adder_chk.sv
module serial_moore_adder_chk
    import serial_add_pkg::*;
#(
    parameter int OP_W  = 8,
    parameter int CNT_W = $clog2(OP_W + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             go,
    input logic             busy,
    input logic             done,
    input logic [OP_W:0]    sum_out,
    input logic [CNT_W-1:0] cnt,
    input add_state_e       state
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OP_W);

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (go && !busy) |=> (busy && sum_out == '0)); // R2
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (go && !busy) |=> (state == ST_G0)); // R8
    AST_GO_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && go && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R4
    AST_DONE_AFTER_FLUSH: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(busy) && $past(cnt) == LAST)); // R7
    AST_SUM_LAG: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> (sum_out[OP_W-1] == $past(state[0]))); // R7
    AST_CARRY_TOP: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == LAST) |=> (sum_out[OP_W] == $past(state[1]))); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !go) |=> $stable(sum_out)); // R6
    AST_CHAIN_START: assert property (@(posedge clk) disable iff (rst)
        (done && go) |=> busy); // R9
endmodule

bind serial_moore_adder serial_moore_adder_chk #(.OP_W(OP_W)) u_chk (
    .clk(clk), .rst(rst), .go(go), .busy(busy), .done(done),
    .sum_out(sum_out), .cnt(step_cnt), .state(fsm_state)
);

// File: tb/serial_moore_adder_bench.sv
`timescale 1ns/100ps
module serial_moore_adder_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       go = 1'b0;
    logic [7:0] a_in = '0;
    logic [7:0] b_in = '0;
    logic [8:0] sum_out;
    logic       busy;
    logic       done;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    serial_moore_adder u_serial_moore_adder (
        .clk(clk), .rst(rst), .go(go), .a_in(a_in), .b_in(b_in),
        .sum_out(sum_out), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // At the negedge right after the accepting edge: follow the run to done.
    // mess=1 toggles go and operands during the run (R5).
    task automatic follow_run(input logic [7:0] x, input logic [7:0] y,
                              input bit mess, input string tag);
        logic [8:0] exp_sum;
        exp_sum = 9'(x) + 9'(y);
        check(busy == 1'b1, "R2", {tag, " busy after start"}, int'(busy), 1);
        check(sum_out == 9'd0, "R2", {tag, " result cleared"}, int'(sum_out), 0);
        for (int i = 0; i < 8; i++) begin
            if (mess) begin
                go   = ~go;
                a_in = a_in + 8'd37;
                b_in = b_in ^ 8'h5A;
            end
            @(negedge clk);
            check(busy && !done, "R7", {tag, " still busy"}, int'({busy, done}), 2);
        end
        if (mess) go = 1'b1;
        @(negedge clk);
        check(done == 1'b1, "R7", {tag, " done after 9 busy cycles"}, int'(done), 1);
        check(busy == 1'b0, "R4", {tag, " busy low with done"}, int'(busy), 0);
        check(sum_out == exp_sum, "R3", {tag, " sum"}, int'(sum_out), int'(exp_sum));
        if (mess) check(sum_out == exp_sum, "R5", {tag, " unaffected"}, int'(sum_out), int'(exp_sum));
    endtask

    task automatic run_add(input logic [7:0] x, input logic [7:0] y,
                           input bit mess, input string tag);
        logic [8:0] held;
        @(negedge clk);
        go = 1'b1; a_in = x; b_in = y;
        @(negedge clk);
        if (!mess) go = 1'b0;
        follow_run(x, y, mess, tag);
        held = sum_out;
        go = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R4", {tag, " done one cycle"}, int'(done), 0);
        check(busy == 1'b0, "R5", {tag, " no restart from busy go"}, int'(busy), 0);
        check(sum_out == held, "R6", {tag, " result held"}, int'(sum_out), int'(held));
    endtask

    task automatic test_reset();
        rst = 1'b1; go = 1'b1; a_in = 8'hFF; b_in = 8'hFF;
        repeat (3) @(negedge clk);
        go = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        check(sum_out == 9'd0, "R1", "reset sum", int'(sum_out), 0);
        check(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
        check(done == 1'b0, "R1", "reset done", int'(done), 0);
    endtask

    task automatic test_idle_hold();
        logic [8:0] held;
        held = sum_out;
        for (int i = 0; i < 6; i++) begin
            a_in = 8'(i * 41); b_in = 8'(255 - i * 13);
            @(negedge clk);
            check(sum_out == held && !busy, "R6", "idle hold", int'(sum_out), int'(held));
        end
    endtask

    // Overflowing add, go kept high through done, then 0+0 (R8, R9).
    task automatic test_chain();
        @(negedge clk);
        go = 1'b1; a_in = 8'hFF; b_in = 8'hFF;
        @(negedge clk);
        follow_run(8'hFF, 8'hFF, 1'b0, "chainA");
        a_in = 8'h00; b_in = 8'h00;
        @(negedge clk);
        check(busy == 1'b1, "R9", "restart after done", int'(busy), 1);
        go = 1'b0;
        follow_run(8'h00, 8'h00, 1'b0, "chainB");
        check(sum_out == 9'd0, "R8", "no leftover carry", int'(sum_out), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        test_reset();
        run_add(8'd0,   8'd0,   1'b0, "zero");
        run_add(8'd1,   8'd1,   1'b0, "one_one");
        run_add(8'd170, 8'd85,  1'b0, "alt");
        run_add(8'd255, 8'd1,   1'b0, "ripple");
        run_add(8'd128, 8'd128, 1'b0, "top_carry");
        run_add(8'd200, 8'd100, 1'b1, "busy_noise");
        test_idle_hold();
        test_chain();
        run_add(8'd37,  8'd219, 1'b0, "mixed");
        summary();
    end
endmodule